// File: doc/BRIEF.md
# Dual-Accumulator Arithmetic and Shift Unit

This block holds two 12-bit accumulators, a primary (A) and a secondary (B), and applies one operation per execute strobe to them. The operations are load, add, subtract, AND, compare, single and double shifts, one multiply step, single-bit input capture and single-bit output drive. Each operation takes an external 12-bit operand.

A one-shot select strobe steers only the next operation to B. After that operation the selection falls back to A. Every operation updates four condition flags (less-than, equal, no-carry and the old bit 0 of A). A sign flag follows the result of the operation before the most recent one. A separate branch unit reads these flags.

Instruction fetch, memory addressing and branching are handled outside the block. The caller presents an operation code and an operand, and pulses the execute input for one clock per operation.

Top module: `acc_pair_unit`

## Requirements
- R1: A pulse on `sel_b_i` makes the next executed operation act on B instead of A. The operation after that acts on A again. With no pulse, operations act on A.
- R2: The codes on `op_i` are: 0 load, 1 add, 2 subtract, 3 AND, 4 compare, 5 logical right shift, 6 left shift, 7 arithmetic right shift, 8 double right shift, 9 double left shift, 10 multiply step, 11 input capture and 12 output drive. Codes 13 to 15 leave both accumulators unchanged. Load writes the operand, add writes the 12-bit sum and AND writes the bitwise AND, each into the selected accumulator. After an add, `nc_o` is 1 exactly when the sum does not exceed 12 bits.
- R3: Subtract writes the selected accumulator minus the operand, modulo 4096. After any operation other than add, `nc_o` is 1 exactly when the accumulator was below the operand. So 0 minus 1 gives 0xFFF with `nc_o` = 1.
- R4: Compare leaves both accumulators unchanged. After every operation, `lt_o` shows whether the operand was below the pre-operation value of the selected accumulator, unsigned, and `eq_o` shows whether the two were equal.
- R5: After every operation, `a0_o` holds bit 0 of A as it was before that operation, even when B was selected.
- R6: `mi_o` shows bit 11 of the selected accumulator's result from the operation before the most recent one. It changes only when an operation executes, and it is 0 until two operations have executed.
- R7: The left shift moves the selected accumulator up by one and puts 0 in bit 0. On A, the logical right shift fills bit 11 with 0 and the arithmetic right shift copies bit 11. On B, both right shifts copy bit 11.
- R8: The double right shift shifts B right with its sign copied and moves bit 0 of B into bit 11 of A. The double left shift shifts each accumulator left on its own, with 0 into bit 0 and no bit passing from A to B.
- R9: A multiply step adds the operand to B when bit 0 of A is 1, then shifts the 13-bit sum and A right as one value. Twelve steps starting with B = 0 leave the 24-bit product of A and the operand in {B, A}.
- R10: Input capture writes `in_lines_i[operand_i[3:0]]` into bit 0 of the selected accumulator and clears bits 11..1.
- R11: Output drive sets `out_lines_o[operand_i[2:0]]` to the inverse of bit 0 of the selected accumulator and leaves the other output lines unchanged.
- R12: After reset, both accumulators, all flags and all output lines are 0, and A is selected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| exec_i | input | 1 | Execute the operation on `op_i` in this cycle |
| sel_b_i | input | 1 | Steer the next executed operation to B |
| op_i | input | 4 | Operation code |
| operand_i | input | 12 | Operand, also the bit index for input and output operations |
| in_lines_i | input | 16 | External single-bit inputs |
| acc_a_o | output | 12 | Primary accumulator |
| acc_b_o | output | 12 | Secondary accumulator |
| lt_o | output | 1 | Operand was below the accumulator |
| eq_o | output | 1 | Operand was equal to the accumulator |
| nc_o | output | 1 | No carry out of the last add or subtract |
| a0_o | output | 1 | Bit 0 of A before the last operation |
| mi_o | output | 1 | Delayed sign flag |
| out_lines_o | output | 8 | External single-bit outputs |

## Verification
A selection bit that sticks or clears too early puts a result in the wrong accumulator. That shows up on `acc_a_o` or `acc_b_o` in the cycle after the execute strobe. A fault in the sign-delay stage shows up on `mi_o` only one operation later, so checks compare `mi_o` after every operation in long runs, not only once. Faults in the multiply carry or in the B-to-A bit transfer may stay hidden for several steps. They are caught both by comparing after each step and by comparing the full product after twelve steps.

// File: rtl/acc_pkg.sv
package acc_pkg;
  typedef enum logic [3:0] {
    OP_LOAD = 4'd0,
    OP_ADD  = 4'd1,
    OP_SUB  = 4'd2,
    OP_AND  = 4'd3,
    OP_CMP  = 4'd4,
    OP_LSR  = 4'd5,
    OP_LSL  = 4'd6,
    OP_ASR  = 4'd7,
    OP_ASRD = 4'd8,
    OP_LSLD = 4'd9,
    OP_MUL  = 4'd10,
    OP_INP  = 4'd11,
    OP_OUT  = 4'd12
  } acc_op_e;

  typedef struct packed {
    logic lt;
    logic eq;
    logic nc;
    logic a0;
  } acc_flags_t;
endpackage

// File: rtl/acc_alu.sv
module acc_alu
  import acc_pkg::*;
#(
  parameter int W = 12
) (
  input  acc_op_e    op_i,
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  input  logic       sel_b_i,
  input  logic [W-1:0] opd_i,
  input  logic       in_bit_i,
  output logic [W-1:0] a_o,
  output logic [W-1:0] b_o,
  output acc_flags_t flags_o,
  output logic       msb_o
);
  logic [W-1:0] acc, res;
  logic [W:0]   add_s, sub_s, mul_s;
  logic         pair_op;

  assign acc   = sel_b_i ? b_i : a_i;
  assign add_s = {1'b0, acc} + {1'b0, opd_i};
  assign sub_s = {1'b0, acc} + {1'b0, ~opd_i} + {{W{1'b0}}, 1'b1};
  assign mul_s = {1'b0, b_i} + (a_i[0] ? {1'b0, opd_i} : {(W+1){1'b0}});

  always_comb begin
    res     = acc;
    a_o     = a_i;
    b_o     = b_i;
    pair_op = 1'b0;
    unique case (op_i)
      OP_LOAD: res = opd_i;
      OP_ADD:  res = add_s[W-1:0];
      OP_SUB:  res = sub_s[W-1:0];
      OP_AND:  res = acc & opd_i;
      OP_LSR:  res = {sel_b_i & acc[W-1], acc[W-1:1]};
      OP_LSL:  res = {acc[W-2:0], 1'b0};
      OP_ASR:  res = {acc[W-1], acc[W-1:1]};
      OP_INP:  res = {{(W-1){1'b0}}, in_bit_i};
      OP_ASRD: begin
        pair_op = 1'b1;
        b_o = {b_i[W-1], b_i[W-1:1]};
        a_o = {b_i[0], a_i[W-1:1]};
      end
      OP_LSLD: begin
        pair_op = 1'b1;
        b_o = {b_i[W-2:0], 1'b0};
        a_o = {a_i[W-2:0], 1'b0};
      end
      OP_MUL: begin
        pair_op = 1'b1;
        b_o = mul_s[W:1];
        a_o = {mul_s[0], a_i[W-1:1]};
      end
      default: res = acc;
    endcase
    if (!pair_op) begin
      if (sel_b_i) b_o = res;
      else         a_o = res;
    end
  end

  assign msb_o      = sel_b_i ? b_o[W-1] : a_o[W-1];
  assign flags_o.lt = opd_i < acc;
  assign flags_o.eq = opd_i == acc;
  assign flags_o.nc = (op_i == OP_ADD) ? ~add_s[W] : ~sub_s[W];
  assign flags_o.a0 = a_i[0];
endmodule

// File: rtl/acc_sign_delay.sv
module acc_sign_delay (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic adv_i,
  input  logic msb_i,
  output logic mi_o
);
  logic stage_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      stage_q <= 1'b0;
      mi_o    <= 1'b0;
    end else if (adv_i) begin
      stage_q <= msb_i;
      mi_o    <= stage_q;
    end
  end

  assert_mi_hold_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !adv_i |=> $stable(mi_o));
endmodule

// File: rtl/acc_pair_unit.sv
module acc_pair_unit
  import acc_pkg::*;
#(
  parameter int W       = 12,
  parameter int NUM_IN  = 16,
  parameter int NUM_OUT = 8
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               exec_i,
  input  logic               sel_b_i,
  input  logic [3:0]         op_i,
  input  logic [W-1:0]       operand_i,
  input  logic [NUM_IN-1:0]  in_lines_i,
  output logic [W-1:0]       acc_a_o,
  output logic [W-1:0]       acc_b_o,
  output logic               lt_o,
  output logic               eq_o,
  output logic               nc_o,
  output logic               a0_o,
  output logic               mi_o,
  output logic [NUM_OUT-1:0] out_lines_o
);
  localparam int IN_IDX_W  = $clog2(NUM_IN);
  localparam int OUT_IDX_W = $clog2(NUM_OUT);

  acc_op_e    op;
  logic [W-1:0] a_q, b_q, a_nx, b_nx;
  logic       use_b_q;
  acc_flags_t flags_q, flags_nx;
  logic       msb_nx, in_bit, acc_bit0;
  logic [OUT_IDX_W-1:0] out_idx;

  assign op       = acc_op_e'(op_i);
  assign in_bit   = in_lines_i[operand_i[IN_IDX_W-1:0]];
  assign out_idx  = operand_i[OUT_IDX_W-1:0];
  assign acc_bit0 = use_b_q ? b_q[0] : a_q[0];

  acc_alu #(.W(W)) u_alu (
    .op_i    (op),
    .a_i     (a_q),
    .b_i     (b_q),
    .sel_b_i (use_b_q),
    .opd_i   (operand_i),
    .in_bit_i(in_bit),
    .a_o     (a_nx),
    .b_o     (b_nx),
    .flags_o (flags_nx),
    .msb_o   (msb_nx)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      a_q     <= '0;
      b_q     <= '0;
      flags_q <= '0;
    end else if (exec_i) begin
      a_q     <= a_nx;
      b_q     <= b_nx;
      flags_q <= flags_nx;
    end
  end

  // select strobe wins over the clear caused by an execute in the same cycle
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      use_b_q <= 1'b0;
    else if (sel_b_i) use_b_q <= 1'b1;
    else if (exec_i)  use_b_q <= 1'b0;
  end

  acc_sign_delay u_sign (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .adv_i (exec_i),
    .msb_i (msb_nx),
    .mi_o  (mi_o)
  );

  for (genvar g = 0; g < NUM_OUT; g++) begin : g_out
    logic line_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) line_q <= 1'b0;
      else if (exec_i && op == OP_OUT && out_idx == OUT_IDX_W'(g)) line_q <= ~acc_bit0;
    end
    assign out_lines_o[g] = line_q;
  end

  assign acc_a_o = a_q;
  assign acc_b_o = b_q;
  assign lt_o    = flags_q.lt;
  assign eq_o    = flags_q.eq;
  assign nc_o    = flags_q.nc;
  assign a0_o    = flags_q.a0;

  assert_one_shot_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (exec_i && use_b_q && !sel_b_i && op == OP_LOAD) |=>
      (acc_b_o == $past(operand_i) && acc_a_o == $past(acc_a_o) && !use_b_q));

  assert_sub_wrap_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (exec_i && !use_b_q && op == OP_SUB) |=>
      (acc_a_o == $past(acc_a_o - operand_i) && nc_o == ($past(acc_a_o) < $past(operand_i))));

  assert_cmp_keep_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (exec_i && op == OP_CMP) |=>
      ($stable(acc_a_o) && $stable(acc_b_o) &&
       eq_o == ($past(operand_i) == $past(use_b_q ? acc_b_o : acc_a_o))));

  assert_a0_prior_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    exec_i |=> a0_o == $past(acc_a_o[0]));

  assert_out_inv_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (exec_i && op == OP_OUT) |=>
      out_lines_o[$past(out_idx)] == !$past(use_b_q ? acc_b_o[0] : acc_a_o[0]));
endmodule

// File: tb/sim_acc_pair_unit.sv
`timescale 1ns/1ps
module sim_acc_pair_unit;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        exec = 1'b0;
  logic        pfx = 1'b0;
  logic [3:0]  op = '0;
  logic [11:0] opd = '0;
  logic [15:0] inl = '0;
  logic [11:0] a_o, b_o;
  logic        lt, eq, nc, a0, mi;
  logic [7:0]  outl;

  int n_cmp = 0;
  int n_bad = 0;
  bit done = 0;
  int cycles = 0;

  logic [11:0] ma, mb;
  bit msel, mlt, meq, mnc, ma0, ms1, mmi;
  logic [7:0] mout;

  always #2.5 clk = ~clk;

  acc_pair_unit u0 (
    .clk_i(clk), .rst_ni(rst_n), .exec_i(exec), .sel_b_i(pfx), .op_i(op),
    .operand_i(opd), .in_lines_i(inl), .acc_a_o(a_o), .acc_b_o(b_o),
    .lt_o(lt), .eq_o(eq), .nc_o(nc), .a0_o(a0), .mi_o(mi), .out_lines_o(outl)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  function automatic string tag_of(input logic [3:0] o);
    case (o)
      4'd2: return "R3";
      4'd4: return "R4";
      4'd5, 4'd6, 4'd7: return "R7";
      4'd8, 4'd9: return "R8";
      4'd10: return "R9";
      4'd11: return "R10";
      4'd12: return "R11";
      default: return "R2";
    endcase
  endfunction

  // entered and left at a falling edge
  task automatic step(input logic [3:0] o, input logic [11:0] d, input bit use_b, input string tag);
    logic [11:0] acc, res, na, nb;
    logic [12:0] s;
    int sum;
    bit pair;
    if (use_b) begin
      pfx = 1'b1;
      @(negedge clk);
      pfx = 1'b0;
      msel = 1;
    end
    op = o; opd = d; inl = 16'($urandom); exec = 1'b1;
    @(negedge clk);
    exec = 1'b0;
    acc = msel ? mb : ma; res = acc; na = ma; nb = mb; pair = 0;
    case (o)
      4'd0: res = d;
      4'd1: res = acc + d;
      4'd2: res = acc - d;
      4'd3: res = acc & d;
      4'd5: res = msel ? 12'($signed(acc) >>> 1) : (acc >> 1);
      4'd6: res = acc << 1;
      4'd7: res = 12'($signed(acc) >>> 1);
      4'd8: begin pair = 1; nb = 12'($signed(mb) >>> 1); na = (ma >> 1) | (mb[0] ? 12'h800 : 12'h000); end
      4'd9: begin pair = 1; nb = mb << 1; na = ma << 1; end
      4'd10: begin
        pair = 1;
        s = 13'(mb) + (ma[0] ? 13'(d) : 13'd0);
        nb = s[12:1];
        na = (ma >> 1) | (s[0] ? 12'h800 : 12'h000);
      end
      4'd11: res = 12'(inl[d[3:0]]);
      4'd12: mout[d[2:0]] = ~acc[0];
      default: res = acc;
    endcase
    if (!pair) begin
      if (msel) nb = res; else na = res;
    end
    sum = acc + d;
    mlt = d < acc; meq = d == acc;
    mnc = (o == 4'd1) ? (sum < 4096) : (acc < d);
    ma0 = ma[0];
    mmi = ms1; ms1 = msel ? nb[11] : na[11];
    ma = na; mb = nb; msel = 0;
    chk({tag, " acc A"}, 32'(a_o), 32'(ma));
    chk({tag, " acc B"}, 32'(b_o), 32'(mb));
    chk({(o == 4'd2) ? "R3" : "R4", " nc"}, 32'(nc), 32'(mnc));
    chk("R4 lt", 32'(lt), 32'(mlt));
    chk("R4 eq", 32'(eq), 32'(meq));
    chk("R5 a0", 32'(a0), 32'(ma0));
    chk("R6 mi", 32'(mi), 32'(mmi));
    chk({(o == 4'd12) ? "R11" : tag, " out"}, 32'(outl), 32'(mout));
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000 && !done) begin
      done = 1;
      n_bad++;
      $display("FAIL watchdog: actual %0d cycles expected below 150000", cycles);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    ma = 0; mb = 0; msel = 0; mlt = 0; meq = 0; mnc = 0; ma0 = 0; ms1 = 0; mmi = 0; mout = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R12 reset state
    chk("R12 acc A", 32'(a_o), 0);
    chk("R12 acc B", 32'(b_o), 0);
    chk("R12 flags", 32'({lt, eq, nc, a0, mi}), 0);
    chk("R12 out", 32'(outl), 0);

    // R1 prefix steers exactly one operation
    step(4'd0, 12'h123, 1, "R1");
    chk("R1 B loaded", 32'(b_o), 32'h123);
    step(4'd0, 12'h456, 0, "R1");
    chk("R1 back to A", 32'(a_o), 32'h456);
    chk("R1 B kept", 32'(b_o), 32'h123);

    // R3 zero minus one
    step(4'd0, 12'h000, 0, "R3");
    step(4'd2, 12'h001, 0, "R3");
    chk("R3 0-1 value", 32'(a_o), 32'hFFF);
    chk("R3 0-1 nc", 32'(nc), 1);
    // R2 add overflow clears nc
    step(4'd1, 12'h001, 0, "R2");
    chk("R2 add carry nc", 32'(nc), 0);
    chk("R2 add wrap", 32'(a_o), 0);

    // R6 sign lag
    step(4'd0, 12'h800, 0, "R6");
    step(4'd2, 12'h001, 0, "R6");
    chk("R6 after load+sub", 32'(mi), 1);
    step(4'd4, 12'h000, 0, "R6");
    chk("R6 one later", 32'(mi), 0);

    // R4 compare
    step(4'd0, 12'h100, 0, "R4");
    step(4'd4, 12'h0FF, 0, "R4");
    chk("R4 lt set", 32'(lt), 1);
    step(4'd4, 12'h100, 0, "R4");
    chk("R4 eq set", 32'(eq), 1);

    // R7 right shifts of B sign-extend
    step(4'd0, 12'h802, 1, "R7");
    step(4'd5, 12'h000, 1, "R7");
    chk("R7 B lsr", 32'(b_o), 32'hC01);
    step(4'd0, 12'h802, 0, "R7");
    step(4'd5, 12'h000, 0, "R7");
    chk("R7 A lsr", 32'(a_o), 32'h401);

    // R8 double shifts
    step(4'd0, 12'h001, 1, "R8");
    step(4'd0, 12'h800, 0, "R8");
    step(4'd9, 12'h000, 0, "R8");
    chk("R8 no A->B", 32'(b_o), 32'h002);
    step(4'd8, 12'h000, 0, "R8");
    chk("R8 B0 into A11", 32'(a_o), 32'h000);

    // R10 / R11 input and output
    for (int k = 0; k < 16; k++) step(4'd11, 12'(k), k[0], "R10");
    for (int k = 0; k < 16; k++) begin
      step(4'd0, 12'(k >> 3), 0, "R11");
      step(4'd12, 12'(k), 0, "R11");
    end

    // R9 twelve-step multiply on random and edge pairs
    for (int p = 0; p < 40; p++) begin
      logic [11:0] x, y;
      x = (p == 0) ? 12'hFFF : 12'($urandom);
      y = (p == 0) ? 12'hFFF : (p == 1 ? 12'h000 : 12'($urandom));
      step(4'd0, y, 0, "R9");
      step(4'd0, 12'h000, 1, "R9");
      for (int s = 0; s < 12; s++) step(4'd10, x, 0, "R9");
      chk("R9 product", 32'({b_o, a_o}), 32'(x) * 32'(y));
    end

    // mixed sweep of all codes
    for (int n = 0; n < 3000; n++) begin
      logic [3:0] o;
      o = 4'($urandom_range(0, 15));
      step(o, 12'($urandom), ($urandom_range(0, 2) == 0), tag_of(o));
    end

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule